// File: doc/BRIEF.md
# Open-Drain Line Direction Arbiter

This block joins two half-duplex open-drain data lines, one facing a controller and one facing a card, so that a level driven on either of them is copied onto the other. Neither side is fixed as the sender. While both lines rest high the pair is idle. The first line seen to fall becomes the master of the transfer. The block then drives the opposite line, the slave, and leaves the master line alone.

Each line enters through a multi-flop synchroniser. The block acts on a line only through two enables: a pull-down enable, and a short active pull-up enable that speeds the rising edge once the line is released. The slave is pulled low a fixed number of cycles after the master falls. When the master rises again, the pull-down is dropped and a pull-up pulse of fixed length is fired on the slave. The pair then returns to idle and a new master can be chosen. An enable input held low keeps both lines released, which models an inactive mode.

Both timings are parameters counted in clock cycles (`EDGE_DLY`, `PU_LEN`). Together they must fit well inside one bit period of a line that toggles at up to 1 MHz.

Top module: `line_dir_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising edge, all four drive enables are 0 after that edge, and any transfer in progress is abandoned. After reset no drive is asserted until a falling edge elects a master.
- R2: A side is elected master only if it falls in a cycle where both synchronised lines were high in the previous cycle. The master side's own pull-down and pull-up enables stay 0 for the whole transfer.
- R3: If both lines fall in the same sampled cycle, the controller side becomes the master and the card side is the slave.
- R4: Once a master is elected, a falling edge on the slave line (including one caused by the block's own pull-down) elects nothing and changes nothing until the pair is idle again.
- R5: Count edge n as the rising clock edge at which the master's new low level is first captured. The slave pull-down is 1 from edge n+EDGE_DLY+2 onward, and not before.
- R6: Count edge m as the edge at which the master's high level is first captured. If the slave pull-down was on, it turns off at edge m+2. At that same edge the slave pull-up turns on, and it stays on for exactly PU_LEN cycles.
- R7: When the pull-up pulse ends, all enables are 0 and election is re-armed, so the next transfer may start from either side.
- R8: If the master rises before the pull-down delay has run out (m ≤ n+EDGE_DLY) while the slave line is high, neither slave enable is ever asserted.
- R9: If the master rises before the pull-down delay has run out while the slave line is low, no pull-down is asserted. A pull-up pulse of PU_LEN cycles starts at edge m+2.
- R10: While `en_i` is low, all four enables are 0 in the same cycle, with no clock edge needed. Any transfer is abandoned, and a falling line elects no master.
- R11: At no time is more than one of the four drive enables equal to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Block enable; low releases both lines |
| ctl_line_i | input | 1 | Controller-side line level, asynchronous |
| crd_line_i | input | 1 | Card-side line level, asynchronous |
| ctl_pd_o | output | 1 | Pull-down enable for the controller line |
| ctl_pu_o | output | 1 | Active pull-up enable for the controller line |
| crd_pd_o | output | 1 | Pull-down enable for the card line |
| crd_pu_o | output | 1 | Active pull-up enable for the card line |

## Verification
The hardest path to reach is the early release with the slave held low (R9). The slave must fall after the master has been elected, so that the fall is not an election edge, and it must still be low in the synchronised cycle where the master's rise is seen. The bench reaches this path by modelling both wires as wired-AND of an external driver and the block's pull-down. It pulls the slave low one cycle after the master falls and keeps it low until two cycles after the master rises. The same wire model also makes the block's own pull-down feed back as a slave falling edge, which exercises the anti-latch lockout (R4) on every transfer.

// File: rtl/arb_pkg.sv
// Package: shared types for the line direction arbiter.
// Assumes: side index 0 is the controller line and index 1 is the card line.
package arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT      = 2'd1,
        ST_SLAVE_LOW = 2'd2,
        ST_PULLUP    = 2'd3
    } arb_state_t;

    typedef enum logic {
        SIDE_CTL = 1'b0,
        SIDE_CRD = 1'b1
    } side_t;

endpackage

// File: rtl/line_sync.sv
// Module: line_sync
// Brings WIDTH asynchronous line levels into the clock domain through STAGES flops.
// Assumes: STAGES >= 2. Reset value is high, the idle level of an open-drain line.
module line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    // Shift chain: each stage takes the one before it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '1;
        end else begin
            for (int i = STAGES - 1; i > 0; i--) begin
                stg_q[i] <= stg_q[i-1];
            end
            stg_q[0] <= d_i;
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/edge_track.sv
// Module: edge_track
// Keeps the previous synchronised level of each line and flags falling edges.
// Assumes: the inputs are already synchronised. Reset value is high, so no edge is seen out of reset.
module edge_track #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] prev_o,
    output logic [WIDTH-1:0] fall_o
);

    logic [WIDTH-1:0] prev_q;

    // History register: one cycle of each line's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lvl_i;
    end

    // Edge detect, generated per line.
    for (genvar g = 0; g < WIDTH; g++) begin : g_fall
        assign fall_o[g] = prev_q[g] & ~lvl_i[g];
    end

    assign prev_o = prev_q;

endmodule

// File: rtl/cycle_timer.sv
// Module: cycle_timer
// Up-counter that reports when it reaches a terminal value chosen by its user.
// Assumes: the user holds clear_i whenever it changes limit_i or stops timing.
module cycle_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic [CW-1:0] limit_i,
    output logic          done_o
);

    logic [CW-1:0] cnt_q;

    // Count cycles since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = (cnt_q == limit_i);

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |-> (cnt_q <= limit_i)); // R5

endmodule

// File: rtl/arb_fsm.sv
// Module: arb_fsm
// Elects the master side, times the slave pull-down and the pull-up pulse,
// and maps the state onto per-side drive enables.
// Assumes: lvl_i, prev_i and fall_i come from synchronised lines. Index 0 is the controller side.
module arb_fsm
    import arb_pkg::*;
#(
    parameter int EDGE_DLY = 4,
    parameter int PU_LEN   = 3,
    parameter int CW       = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [1:0]    lvl_i,
    input  logic [1:0]    prev_i,
    input  logic [1:0]    fall_i,
    input  logic          tmr_done_i,
    output logic          tmr_clear_o,
    output logic [CW-1:0] tmr_limit_o,
    output logic [1:0]    pd_o,
    output logic [1:0]    pu_o
);

    localparam logic [CW-1:0] DLY_LAST = CW'(EDGE_DLY - 1);
    localparam logic [CW-1:0] PU_LAST  = CW'(PU_LEN - 1);

    arb_state_t state_q, state_d;
    side_t      master_q, master_d;
    logic       both_idle;
    logic       mst_high, slv_high;

    assign both_idle = &prev_i;
    assign mst_high  = lvl_i[master_q];
    assign slv_high  = lvl_i[~master_q];

    // Next-state and election logic.
    always_comb begin
        state_d  = state_q;
        master_d = master_q;
        if (!en_i) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (both_idle && fall_i[SIDE_CTL]) begin
                        state_d  = ST_WAIT;
                        master_d = SIDE_CTL;
                    end else if (both_idle && fall_i[SIDE_CRD]) begin
                        state_d  = ST_WAIT;
                        master_d = SIDE_CRD;
                    end
                end
                ST_WAIT: begin
                    if (mst_high)        state_d = slv_high ? ST_IDLE : ST_PULLUP;
                    else if (tmr_done_i) state_d = ST_SLAVE_LOW;
                end
                ST_SLAVE_LOW: begin
                    if (mst_high) state_d = ST_PULLUP;
                end
                default: begin
                    if (tmr_done_i) state_d = ST_IDLE;
                end
            endcase
        end
    end

    // State and master registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            master_q <= SIDE_CTL;
        end else begin
            state_q  <= state_d;
            master_q <= master_d;
        end
    end

    // Timer control: restart on every state change, hold at zero where unused.
    assign tmr_clear_o = (state_d != state_q) || (state_q == ST_IDLE) || (state_q == ST_SLAVE_LOW);
    assign tmr_limit_o = (state_q == ST_PULLUP) ? PU_LAST : DLY_LAST;

    // Drive enables per side: only the slave side is ever driven.
    for (genvar g = 0; g < 2; g++) begin : g_drive
        assign pd_o[g] = en_i && (state_q == ST_SLAVE_LOW) && (master_q != side_t'(g));
        assign pu_o[g] = en_i && (state_q == ST_PULLUP)    && (master_q != side_t'(g));
    end

    AST_PRIO_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_q == ST_IDLE && both_idle && (&fall_i)) |=> (master_q == SIDE_CTL)); // R3

    AST_MASTER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ((state_q == ST_IDLE) || $stable(master_q))); // R4

    AST_PU_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULLUP && $past(state_q) != ST_PULLUP) |-> $past(lvl_i[master_q])); // R6

    AST_MASTER_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> !(pd_o[master_q] || pu_o[master_q])); // R2

endmodule

// File: rtl/line_dir_arbiter.sv
// Module: line_dir_arbiter (top)
// Links a controller-side and a card-side open-drain line. The first line to fall
// becomes the master, and its level is copied onto the other line through pull-down
// and active pull-up enables.
// Assumes: both line inputs are asynchronous, and EDGE_DLY + PU_LEN is far shorter than one bit period.
module line_dir_arbiter
    import arb_pkg::*;
#(
    parameter int EDGE_DLY    = 4,
    parameter int PU_LEN      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic ctl_line_i,
    input  logic crd_line_i,
    output logic ctl_pd_o,
    output logic ctl_pu_o,
    output logic crd_pd_o,
    output logic crd_pu_o
);

    localparam int TMAX = (EDGE_DLY > PU_LEN) ? EDGE_DLY : PU_LEN;
    localparam int CW   = (TMAX < 2) ? 1 : $clog2(TMAX);

    logic [1:0]    lvl, prev, fall, pd, pu;
    logic          tmr_clear, tmr_done;
    logic [CW-1:0] tmr_limit;

    line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({crd_line_i, ctl_line_i}),
        .q_o   (lvl)
    );

    edge_track #(.WIDTH(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl),
        .prev_o (prev),
        .fall_o (fall)
    );

    cycle_timer #(.CW(CW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (tmr_clear),
        .limit_i (tmr_limit),
        .done_o  (tmr_done)
    );

    arb_fsm #(.EDGE_DLY(EDGE_DLY), .PU_LEN(PU_LEN), .CW(CW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .lvl_i       (lvl),
        .prev_i      (prev),
        .fall_i      (fall),
        .tmr_done_i  (tmr_done),
        .tmr_clear_o (tmr_clear),
        .tmr_limit_o (tmr_limit),
        .pd_o        (pd),
        .pu_o        (pu)
    );

    assign ctl_pd_o = pd[SIDE_CTL];
    assign ctl_pu_o = pu[SIDE_CTL];
    assign crd_pd_o = pd[SIDE_CRD];
    assign crd_pu_o = pu[SIDE_CRD];

    AST_ONE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ctl_pd_o, ctl_pu_o, crd_pd_o, crd_pu_o}) <= 1); // R11

    AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !(ctl_pd_o || ctl_pu_o || crd_pd_o || crd_pu_o)); // R10

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst_n) == 1'b0 |-> !(ctl_pd_o || ctl_pu_o || crd_pd_o || crd_pu_o)); // R1

endmodule

// File: tb/tb_line_dir_arbiter.sv
module tb_line_dir_arbiter;

    localparam int DLY = 4;
    localparam int PU  = 3;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic en    = 1'b1;
    logic ctl_ext = 1'b0;
    logic crd_ext = 1'b0;
    logic ctl_line, crd_line;
    logic ctl_pd, ctl_pu, crd_pd, crd_pu;
    int   total = 0;
    int   bad   = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    // Open-drain wires: low when the outside world or the block pulls down.
    assign ctl_line = ~(ctl_ext | ctl_pd);
    assign crd_line = ~(crd_ext | crd_pd);

    line_dir_arbiter #(.EDGE_DLY(DLY), .PU_LEN(PU), .SYNC_STAGES(2)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .ctl_line_i (ctl_line),
        .crd_line_i (crd_line),
        .ctl_pd_o   (ctl_pd),
        .ctl_pu_o   (ctl_pu),
        .crd_pd_o   (crd_pd),
        .crd_pu_o   (crd_pu)
    );

    function automatic logic [3:0] outs();
        return {ctl_pd, ctl_pu, crd_pd, crd_pu};
    endfunction

    // Expected slave {pd,pu} at sample j after the master falls at index 0 and rises at index hold.
    function automatic logic [1:0] exp_slave(int j, int hold, bit slave_low);
        logic pd, pu;
        pd = (hold > DLY) && (j >= DLY + 3) && (j < hold + 3);
        pu = ((hold > DLY) || slave_low) && (j >= hold + 3) && (j < hold + 3 + PU);
        return {pd, pu};
    endfunction

    // Place the slave enables on the side opposite the master.
    function automatic logic [3:0] place(bit m_crd, logic [1:0] sl);
        return m_crd ? {sl, 2'b00} : {2'b00, sl};
    endfunction

    task automatic check4(string req, logic [3:0] act, logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: act=%b exp=%b", req, $time, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_ext(bit m_crd, bit mst, bit slv);
        if (m_crd) begin crd_ext = mst; ctl_ext = slv; end
        else       begin ctl_ext = mst; crd_ext = slv; end
    endtask

    // One transfer. mode 0: slave free; 1: slave held low after election; 2: both fall together.
    task automatic xfer(string req, bit m_crd, int hold, int mode);
        int  n_cyc;
        bit  slave_low;
        n_cyc     = hold + PU + 6;
        slave_low = (mode != 0);
        for (int idx = 0; idx < n_cyc; idx++) begin
            bit s;
            s = (mode == 2) ? (idx < hold + 2) :
                (mode == 1) ? ((idx >= 1) && (idx < hold + 2)) : 1'b0;
            set_ext(m_crd, idx < hold, s);
            step();
            check4(req, outs(), place(m_crd, exp_slave(idx + 1, hold, slave_low)));
        end
        set_ext(m_crd, 1'b0, 1'b0);
        repeat (2) step();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R7 watchdog: act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        check4("R1 in reset", outs(), 4'b0000);
        repeat (3) step();
        check4("R1 in reset", outs(), 4'b0000);
        rst_n = 1'b1;
        repeat (4) step();
        check4("R1 after reset", outs(), 4'b0000);

        // Directed corners.
        xfer("R2 R4 R5 R6 R7 ctl master", 1'b0, 12, 0);
        xfer("R2 R4 R5 R6 R7 crd master", 1'b1, 12, 0);
        xfer("R5 R6 hold=DLY+1 one-cycle pd", 1'b0, DLY + 1, 0);
        xfer("R8 hold=DLY no drive", 1'b1, DLY, 0);
        xfer("R8 hold=1 no drive", 1'b0, 1, 0);
        xfer("R9 early release slave low", 1'b0, 3, 1);
        xfer("R9 early release slave low crd", 1'b1, 2, 1);
        xfer("R3 simultaneous fall ctl wins", 1'b0, 10, 2);
        xfer("R3 simultaneous short hold", 1'b0, 2, 2);

        // R10: dropping enable mid-transfer releases at once.
        ctl_ext = 1'b1;
        repeat (DLY + 4) step();
        check4("R10 pd before disable", outs(), 4'b0010);
        en = 1'b0;
        #1;
        check4("R10 same-cycle release", outs(), 4'b0000);
        repeat (2) step();
        check4("R10 held released", outs(), 4'b0000);
        ctl_ext = 1'b0;
        repeat (3) step();
        crd_ext = 1'b1;
        for (int k = 0; k < DLY + 8; k++) begin
            step();
            check4("R10 no election while off", outs(), 4'b0000);
        end
        crd_ext = 1'b0;
        repeat (3) step();
        en = 1'b1;
        repeat (3) step();
        check4("R10 back on idle", outs(), 4'b0000);
        xfer("R7 R10 after re-enable", 1'b1, 9, 0);

        // R1: reset during a transfer.
        crd_ext = 1'b1;
        repeat (DLY + 4) step();
        check4("R1 pd before reset", outs(), 4'b1000);
        rst_n = 1'b0;
        step();
        check4("R1 reset mid-transfer", outs(), 4'b0000);
        crd_ext = 1'b0;
        repeat (2) step();
        rst_n = 1'b1;
        repeat (3) step();
        check4("R1 idle after reset", outs(), 4'b0000);

        // Random transfers, checked cycle by cycle (R11 implied by the exact 4-bit compare).
        for (int t = 0; t < 60; t++) begin
            bit m_crd;
            int hold, mode;
            m_crd = $urandom_range(1, 0) == 1;
            hold  = $urandom_range(30, 1);
            mode  = ((hold <= DLY) && ($urandom_range(1, 0) == 1)) ? 1 : 0;
            xfer("R2 R5 R6 R7 R8 R9 R11 random", m_crd, hold, mode);
            repeat ($urandom_range(4, 0)) begin
                step();
                check4("R7 idle gap", outs(), 4'b0000);
            end
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule